// File: doc/BRIEF.md
# GPIO Interrupt and Line-State Controller

This block sits beside a modem's serial port and looks after the line-side control of an isolated line interface. It owns four general-purpose pins and a ring-status input. For each pin it keeps a direction and an interrupt enable, and it keeps one more enable for the ring status. It watches the enabled inputs for level changes and reports them on an active-low interrupt, which stays asserted until the host reads the status word. The status word carries the synchronized pin levels and the ring level.

Two pins can carry clocks taken from the carrier in place of a static level. GPIO0 can drive the carrier or the carrier divided by 2, 4 or 8. GPIO3 can drive the carrier itself. A two-bit line code selects on-hook, off-hook, caller-ID or a special state. The code comes either from two register bits or, in hardware mode, from GPIO1 and GPIO2. It is encoded onto two wires toward the isolation barrier as static highs or as carrier phases.

In the low-power mode that allows wake-up, the serial port enable comes back on for an enabled event while the power-down pin is held low. A status read turns it off again.

Top module: `gpio_line_ctrl`

## Requirements
- R1: After reset, every pin is an input (gpioOe = 0), gpioOut = 0, irqN is high, all interrupt enables are clear, both line outputs are high, and serialEn follows pdPin.
- R2: A write with cfgWrEn high loads the register at cfgAddr on the next clock edge. Address 1 holds the direction in bits 3:0 (1 = output, driven onto gpioOe), the pin interrupt enables in bits 7:4 and the ring interrupt enable in bit 8. Address 2 holds the static output values in bits 3:0, the GPIO0 clock mode in bits 6:4 and the GPIO3 carrier select in bit 7. Address 3 holds the caller-ID bit in bit 0, the off-hook bit in bit 1 and the wake-capable power-down select in bit 2. gpioOe keeps its value while no write occurs.
- R3: statusWord is {ring, gpio[3:0]}, taken through a two-flop synchronizer, so it shows a change in the input pins two clock edges after that change.
- R4: A level change on a pin that is an input with its enable set, or a change on ring with its enable set, drives irqN low one edge after the synchronized change. A change on a disabled source or on an output-direction pin leaves irqN high.
- R5: A status read (statusRd high for one edge) with no coincident event returns irqN high after that edge.
- R6: When an enabled event and a status read fall on the same edge, irqN stays low.
- R7: The GPIO0 mode field selects the output: 0 = static bit 0, 1 = carrier, 2 = carrier/2, 3 = carrier/4, 4 = carrier/8. Codes 5 to 7 act as static.
- R8: With the GPIO3 carrier select set, gpioOut[3] follows the carrier. Otherwise it drives static bit 3.
- R9: With hwMode = 1 the line code is {CL, OH} = {gpio1, gpio2}, using the synchronized levels. With hwMode = 0 it is {caller-ID bit, off-hook bit} from address 3. Whichever source is not selected has no effect.
- R10: Line code 00 (on-hook) drives lineA and lineB high. Code 01 (off-hook) drives lineA = carrier and lineB = inverted carrier. Code 10 (caller-ID) drives lineA = carrier and lineB high. Code 11 (special) drives both lines high.
- R11: With pdPin high, serialEn is 1. With pdPin low and the wake select clear, serialEn is 0 even when events occur. With pdPin low and the wake select set, an enabled event raises serialEn on the same edge that drives irqN low, and a status read drops it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | 2 | Register address (1, 2, 3) |
| cfgWrData | input | 9 | Register write data |
| statusRd | input | 1 | Status read strobe, clears the interrupt |
| statusWord | output | 5 | {ring, gpio[3:0]}, synchronized levels |
| gpioIn | input | 4 | Pin input levels |
| gpioOut | output | 4 | Pin output values |
| gpioOe | output | 4 | Pin output enables |
| ringIn | input | 1 | Ring-detect status |
| hwMode | input | 1 | 1 = line code taken from GPIO1/GPIO2 |
| pdPin | input | 1 | Power-down, active low |
| carrier | input | 1 | Carrier clock level, synchronous to clk |
| irqN | output | 1 | Interrupt, active low |
| serialEn | output | 1 | Serial port power enable |
| lineA | output | 1 | First barrier control wire |
| lineB | output | 1 | Second barrier control wire |

## Verification
Raising the interrupt on an input change and clearing it on a status read can fall on the same clock edge. The bench times a ring toggle so that its synchronized change lands on the edge where statusRd is sampled, then checks that irqN is still low once that edge has passed. A later read with no event pending must release irqN. The interrupt itself is swept over all 32 enable patterns with each of the five sources toggled in turn. The expected level comes from the enable bit of the source that was toggled.

// File: rtl/gpio_line_pkg.sv
package gpio_line_pkg;
  // register addresses
  localparam logic [1:0] ADDR_PIN  = 2'd1;
  localparam logic [1:0] ADDR_OUT  = 2'd2;
  localparam logic [1:0] ADDR_LINE = 2'd3;

  // GPIO0 output mode codes
  localparam logic [2:0] G0_STATIC = 3'd0;
  localparam logic [2:0] G0_F0     = 3'd1;
  localparam logic [2:0] G0_DIV2   = 3'd2;
  localparam logic [2:0] G0_DIV4   = 3'd3;
  localparam logic [2:0] G0_DIV8   = 3'd4;

  typedef enum logic [1:0] {
    LS_ONHOOK   = 2'b00,
    LS_OFFHOOK  = 2'b01,
    LS_CALLERID = 2'b10,
    LS_SPECIAL  = 2'b11
  } lineState_e;

  typedef struct packed {
    logic ldPinCfg;
    logic ldOutCfg;
    logic ldLineCfg;
  } cfgStrobe_t;
endpackage

// File: rtl/gpio_line_dp.sv
module gpio_line_dp
  import gpio_line_pkg::*;
#(
  parameter int NUM_GPIO    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int CFG_W       = 2 * NUM_GPIO + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  cfgStrobe_t          strobe,
  input  logic [CFG_W-1:0]    wrData,
  input  logic [NUM_GPIO-1:0] gpioIn,
  input  logic                ringIn,
  input  logic                hwMode,
  input  logic                carrier,
  output logic                eventAny,
  output logic [NUM_GPIO:0]   statusWord,
  output logic [NUM_GPIO-1:0] gpioOut,
  output logic [NUM_GPIO-1:0] gpioOe,
  output logic                lineA,
  output logic                lineB,
  output logic                pdMode1
);
  localparam int SRC_W = NUM_GPIO + 1;
  localparam int DIV_W = 3;

  logic [SYNC_STAGES-1:0][SRC_W-1:0] syncPipe;
  logic [SRC_W-1:0] synced, prevQ, enMask;
  logic [NUM_GPIO-1:0] dirQ, maskQ, outValQ;
  logic ringMaskQ, g3ModQ, clQ, ohQ, pdMode1Q, carPrevQ;
  logic [2:0] g0ModeQ;
  logic [DIV_W-1:0] divQ;
  logic g0Out;
  lineState_e lineCode;
  logic unusedCfg;

  assign unusedCfg = ^wrData;

  // input synchronizer and previous-value register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPipe <= '0;
      prevQ    <= '0;
    end else begin
      syncPipe[0] <= {ringIn, gpioIn};
      for (int k = 1; k < SYNC_STAGES; k++) syncPipe[k] <= syncPipe[k-1];
      prevQ <= synced;
    end
  end
  assign synced     = syncPipe[SYNC_STAGES-1];
  assign statusWord = synced;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ <= '0; maskQ <= '0; ringMaskQ <= 1'b0;
      outValQ <= '0; g0ModeQ <= G0_STATIC; g3ModQ <= 1'b0;
      clQ <= 1'b0; ohQ <= 1'b0; pdMode1Q <= 1'b0;
    end else begin
      if (strobe.ldPinCfg) begin
        dirQ      <= wrData[NUM_GPIO-1:0];
        maskQ     <= wrData[2*NUM_GPIO-1:NUM_GPIO];
        ringMaskQ <= wrData[2*NUM_GPIO];
      end
      if (strobe.ldOutCfg) begin
        outValQ <= wrData[NUM_GPIO-1:0];
        g0ModeQ <= wrData[NUM_GPIO+2:NUM_GPIO];
        g3ModQ  <= wrData[NUM_GPIO+3];
      end
      if (strobe.ldLineCfg) begin
        clQ      <= wrData[0];
        ohQ      <= wrData[1];
        pdMode1Q <= wrData[2];
      end
    end
  end
  assign pdMode1 = pdMode1Q;
  assign gpioOe  = dirQ;

  // change detection on enabled sources
  assign enMask   = {ringMaskQ, maskQ & ~dirQ};
  assign eventAny = |((synced ^ prevQ) & enMask);

  // carrier divider, advances on each carrier rise
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carPrevQ <= 1'b0;
      divQ     <= '0;
    end else begin
      carPrevQ <= carrier;
      if (carrier && !carPrevQ) divQ <= divQ + 1'b1;
    end
  end

  always_comb begin
    case (g0ModeQ)
      G0_F0:   g0Out = carrier;
      G0_DIV2: g0Out = divQ[0];
      G0_DIV4: g0Out = divQ[1];
      G0_DIV8: g0Out = divQ[2];
      default: g0Out = outValQ[0];
    endcase
  end

  for (genvar i = 0; i < NUM_GPIO; i++) begin : g_pin
    if (i == 0) begin : g_clk0
      assign gpioOut[i] = g0Out;
    end else if (i == 3) begin : g_clk3
      assign gpioOut[i] = g3ModQ ? carrier : outValQ[i];
    end else begin : g_static
      assign gpioOut[i] = outValQ[i];
    end
  end

  // line-state select and barrier encoding
  assign lineCode = hwMode ? lineState_e'({synced[1], synced[2]})
                           : lineState_e'({clQ, ohQ});
  always_comb begin
    case (lineCode)
      LS_OFFHOOK:  begin lineA = carrier; lineB = ~carrier; end
      LS_CALLERID: begin lineA = carrier; lineB = 1'b1;     end
      default:     begin lineA = 1'b1;    lineB = 1'b1;     end
    endcase
  end
endmodule

// File: rtl/gpio_line_ctl.sv
module gpio_line_ctl
  import gpio_line_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic              statusRd,
  input  logic              eventAny,
  input  logic              pdPin,
  input  logic              pdMode1,
  output cfgStrobe_t        strobe,
  output logic              irqN,
  output logic              serialEn
);
  logic irqQ, wakeQ, sleepWake;

  always_comb begin
    strobe.ldPinCfg  = cfgWrEn && (cfgAddr == ADDR_W'(ADDR_PIN));
    strobe.ldOutCfg  = cfgWrEn && (cfgAddr == ADDR_W'(ADDR_OUT));
    strobe.ldLineCfg = cfgWrEn && (cfgAddr == ADDR_W'(ADDR_LINE));
  end

  assign sleepWake = !pdPin && pdMode1;

  // an event on the clearing edge wins over the read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqQ  <= 1'b0;
      wakeQ <= 1'b0;
    end else begin
      irqQ  <= eventAny || (irqQ && !statusRd);
      wakeQ <= sleepWake && (eventAny || (wakeQ && !statusRd));
    end
  end

  assign irqN     = ~irqQ;
  assign serialEn = pdPin || wakeQ;
endmodule

// File: rtl/gpio_line_ctrl.sv
module gpio_line_ctrl
  import gpio_line_pkg::*;
#(
  parameter int NUM_GPIO    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 2,
  parameter int CFG_W       = 2 * NUM_GPIO + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [ADDR_W-1:0]   cfgAddr,
  input  logic [CFG_W-1:0]    cfgWrData,
  input  logic                statusRd,
  output logic [NUM_GPIO:0]   statusWord,
  input  logic [NUM_GPIO-1:0] gpioIn,
  output logic [NUM_GPIO-1:0] gpioOut,
  output logic [NUM_GPIO-1:0] gpioOe,
  input  logic                ringIn,
  input  logic                hwMode,
  input  logic                pdPin,
  input  logic                carrier,
  output logic                irqN,
  output logic                serialEn,
  output logic                lineA,
  output logic                lineB
);
  cfgStrobe_t strobe;
  logic eventAny, pdMode1;

  gpio_line_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .statusRd(statusRd), .eventAny(eventAny), .pdPin(pdPin),
    .pdMode1(pdMode1), .strobe(strobe), .irqN(irqN), .serialEn(serialEn)
  );

  gpio_line_dp #(.NUM_GPIO(NUM_GPIO), .SYNC_STAGES(SYNC_STAGES), .CFG_W(CFG_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(cfgWrData),
    .gpioIn(gpioIn), .ringIn(ringIn), .hwMode(hwMode), .carrier(carrier),
    .eventAny(eventAny), .statusWord(statusWord), .gpioOut(gpioOut),
    .gpioOe(gpioOe), .lineA(lineA), .lineB(lineB), .pdMode1(pdMode1)
  );
endmodule

// File: rtl/gpio_line_chk.sv
module gpio_line_chk #(
  parameter int NUM_GPIO = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                eventAny,
  input logic                statusRd,
  input logic                irqN,
  input logic                pdPin,
  input logic                serialEn,
  input logic                cfgWrEn,
  input logic [NUM_GPIO-1:0] gpioOe
);
  // R4
  irq_on_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    eventAny |=> !irqN);
  // R4
  irq_fall_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqN) |-> $past(eventAny));
  // R5
  irq_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !eventAny) |=> irqN);
  // R11
  pd_awake_chk: assert property (@(posedge clk) disable iff (!rstN)
    pdPin |-> serialEn);
  // R2
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrEn |=> $stable(gpioOe));
endmodule

bind gpio_line_ctrl gpio_line_chk #(.NUM_GPIO(NUM_GPIO)) u_chk (
  .clk(clk), .rstN(rstN), .eventAny(eventAny), .statusRd(statusRd),
  .irqN(irqN), .pdPin(pdPin), .serialEn(serialEn), .cfgWrEn(cfgWrEn),
  .gpioOe(gpioOe)
);

// File: tb/tb_gpio_line_ctrl.sv
module tb_gpio_line_ctrl;
  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWrEn = 1'b0, statusRd = 1'b0;
  logic [1:0] cfgAddr = '0;
  logic [8:0] cfgWrData = '0;
  logic [4:0] statusWord;
  logic [3:0] gpioIn = '0, gpioOut, gpioOe;
  logic ringIn = 1'b0, hwMode = 1'b0, pdPin = 1'b1, carrier = 1'b0;
  logic irqN, serialEn, lineA, lineB;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  gpio_line_ctrl dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .statusRd(statusRd), .statusWord(statusWord),
    .gpioIn(gpioIn), .gpioOut(gpioOut), .gpioOe(gpioOe), .ringIn(ringIn),
    .hwMode(hwMode), .pdPin(pdPin), .carrier(carrier), .irqN(irqN),
    .serialEn(serialEn), .lineA(lineA), .lineB(lineB)
  );

  always #10 clk = ~clk;
  always @(posedge clk) carrier <= ~carrier;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [8:0] d);
    @(negedge clk); cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk); cfgWrEn = 1'b0;
  endtask

  task automatic readStatus();
    @(negedge clk); statusRd = 1'b1;
    @(negedge clk); statusRd = 1'b0;
  endtask

  task automatic toggleSrc(input int src);
    @(negedge clk);
    if (src == 4) ringIn = ~ringIn; else gpioIn[src] = ~gpioIn[src];
    repeat (4) @(negedge clk);
  endtask

  task automatic checkLine(input string tag, input logic [1:0] code);
    for (int s = 0; s < 8; s++) begin
      logic ea, eb;
      @(negedge clk);
      case (code)
        2'b01:   begin ea = carrier; eb = ~carrier; end
        2'b10:   begin ea = carrier; eb = 1'b1;     end
        default: begin ea = 1'b1;    eb = 1'b1;     end
      endcase
      check(tag, {lineA, lineB}, {ea, eb});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irqN", irqN, 1);
    check("R1 gpioOe", gpioOe, 0);
    check("R1 gpioOut", gpioOut, 0);
    check("R1 lines", {lineA, lineB}, 2'b11);
    check("R1 serialEn", serialEn, 1);

    // R3 status reflects synchronized levels
    @(negedge clk); gpioIn = 4'b1010; ringIn = 1'b1;
    repeat (2) @(negedge clk);
    check("R3 status", statusWord, 5'b11010);
    @(negedge clk); gpioIn = 4'b0101; ringIn = 1'b0;
    repeat (2) @(negedge clk);
    check("R3 status", statusWord, 5'b00101);
    check("R4 masked stays high", irqN, 1);

    // R4 / R5 sweep over all enable patterns
    for (int m = 0; m < 32; m++) begin
      writeReg(2'd1, 9'((m[4] << 8) | (m[3:0] << 4)));
      readStatus();
      for (int src = 0; src < 5; src++) begin
        toggleSrc(src);
        check($sformatf("R4 mask %0d src %0d", m, src), irqN, !m[src]);
        readStatus();
        check($sformatf("R5 release mask %0d src %0d", m, src), irqN, 1);
      end
    end

    // R4 output-direction pin is ignored
    writeReg(2'd1, 9'h1F2);
    readStatus();
    toggleSrc(1);
    check("R4 output pin ignored", irqN, 1);
    toggleSrc(0);
    check("R4 input pin raises", irqN, 0);
    readStatus();

    // R6 event coincides with clearing read
    writeReg(2'd1, 9'h1F0);
    readStatus();
    @(negedge clk); ringIn = ~ringIn;
    repeat (2) @(negedge clk);
    statusRd = 1'b1;
    @(negedge clk); statusRd = 1'b0;
    check("R6 coincident keeps irq", irqN, 0);
    readStatus();
    check("R5 later read releases", irqN, 1);

    // R2 / R7 / R8 outputs
    writeReg(2'd1, 9'h00F);
    check("R2 gpioOe", gpioOe, 4'hF);
    writeReg(2'd2, 9'h006);
    check("R2 static out", gpioOut, 4'b0110);
    for (int md = 1; md <= 4; md++) begin
      int rises, expR;
      logic prev;
      writeReg(2'd2, 9'(md << 4));
      rises = 0;
      prev = gpioOut[0];
      for (int s = 0; s < 64; s++) begin
        @(negedge clk);
        if (gpioOut[0] && !prev) rises++;
        prev = gpioOut[0];
      end
      expR = 64 >> md;
      check($sformatf("R7 mode %0d rises in range", md),
            (rises >= expR - 1 && rises <= expR + 1), 1);
    end
    writeReg(2'd2, 9'h050);
    check("R7 code 5 is static", gpioOut[0], 0);
    writeReg(2'd2, 9'h080);
    for (int s = 0; s < 6; s++) begin
      @(negedge clk);
      check("R8 gpio3 carrier", gpioOut[3], carrier);
    end
    writeReg(2'd2, 9'h008);
    check("R8 gpio3 static", gpioOut[3], 1);

    // R9 / R10 register-selected line states
    writeReg(2'd1, 9'h000);
    hwMode = 1'b0;
    gpioIn = 4'b0110;
    for (int c = 0; c < 4; c++) begin
      logic [1:0] code;
      code = 2'(c);
      writeReg(2'd3, {7'b0, code[0], code[1]});
      checkLine($sformatf("R10 code %0d", c), code);
    end
    // R9 hardware mode takes pins, register ignored
    writeReg(2'd3, 9'h000);
    @(negedge clk); hwMode = 1'b1; gpioIn = 4'b0010;
    repeat (3) @(negedge clk);
    checkLine("R9 hw caller-ID", 2'b10);
    @(negedge clk); gpioIn = 4'b0100;
    repeat (3) @(negedge clk);
    checkLine("R9 hw off-hook", 2'b01);
    @(negedge clk); hwMode = 1'b0;
    checkLine("R9 back to register", 2'b00);

    // R11 power-down
    writeReg(2'd1, 9'h1F0);
    readStatus();
    @(negedge clk); pdPin = 1'b0;
    @(negedge clk);
    check("R11 mode0 off", serialEn, 0);
    toggleSrc(0);
    check("R11 mode0 no wake", serialEn, 0);
    readStatus();
    writeReg(2'd3, 9'h004);
    check("R11 mode1 asleep", serialEn, 0);
    toggleSrc(0);
    check("R11 wake on event", serialEn, 1);
    check("R11 irq on wake", irqN, 0);
    readStatus();
    check("R11 read sleeps", serialEn, 0);
    @(negedge clk); pdPin = 1'b1;
    @(negedge clk);
    check("R11 pin high on", serialEn, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule